// File: doc/BRIEF.md
# Flash Self-Programming Control Register

This block is the command and status register that sits between a CPU and the flash self-programming unit of a small microcontroller. Software writes a byte to select an operation and set the enable bit. The CPU core then raises a strobe when it executes the store-to-program-memory instruction. The store is honoured only while a short window is open after the enable write. If no strobe arrives in time, the window closes and the command is dropped.

An accepted strobe runs one of five operations: buffer load, page erase, page write, lock-bit set, or re-enabling reads of the read-while-write (RWW) section. The operation is picked from the command bits by a fixed priority. Erase, write and lock-bit set hand off to an external flash array. The enable and command bits stay set until that array reports completion.

The block also does the following:
- It keeps a busy flag that blocks reads of the RWW section after an erase or write aimed there.
- It aborts a loaded page buffer when the re-enable bit is written.
- It captures new lock bits from the low data byte.
- It flags program-memory reads that fall in a short lock/fuse read window.
- It raises a ready interrupt request whenever no operation is enabled.

Top module: `flash_prog_ctl`

## Requirements
- R1: After reset the register reads 0x00, the lock bits read 0x00, the interrupt request is low and no start or abort pulse is active.
- R2: The register reads as {intEnable[7], rwwBusy[6], 0[5], reEnable[4], lockSet[3], pageWrite[2], pageErase[1], enable[0]}. Bit 5 always reads 0. CPU writes never change bit 6.
- R3: readyIrq is high exactly when bit 7 is 1, globalIntEn is 1 and bit 0 is 0. It follows globalIntEn in the same cycle.
- R4: A CPU write with bit 0 set opens a window of WIN_LEN (4) cycles after the write cycle, and a store strobe in any of those cycles is accepted. If no strobe arrives, bits 4:0 read 0 from the cycle after the last window cycle, and no start pulse is produced.
- R5: The operation chosen for an accepted strobe follows this priority: re-enable, then lock set, then page write, then page erase. With none of these bits set, the operation is a buffer load. The matching start pulse (eraseStart, writeStart, lockStart, loadStart) is high in the strobe cycle, and at most one start pulse is ever high.
- R6: A page erase or page write with storeAddr below RWW_WORDS (7168) sets bit 6 from the next cycle. At or above that address, bit 6 is unchanged. Bit 0 and the command bits stay set until flashDone, and they read 0 in the cycle after flashDone.
- R7: An accepted re-enable or buffer load clears bit 6 and bits 4:0 for the next cycle, and starts no flash operation.
- R8: While an erase, write or lock-set operation is in progress, CPU writes leave bits 4:0 unchanged and open no window. Bit 7 stays writable during this time.
- R9: A CPU write with bit 4 set, made while buffer data is held, pulses loadAbort in that cycle and discards the data. Data is held from a buffer load until an abort or a page write start. With no data held, no abort occurs.
- R10: An accepted lock set loads lockBits from storeDataLo on the strobe edge. storeDataHi and storeAddr are ignored.
- R11: A programReadStrobe (progMemRead) in any of the 3 cycles after a write with bits 3 and 0 set drives lockReadHit high in that cycle. In that case lockReadFuse equals storeAddr[0]. Outside that window lockReadHit is low.
- R12: A CPU write with bit 0 clear sets bits 4:0 to 0 and closes any open window, so a later strobe starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| globalIntEn | input | 1 | CPU global interrupt enable flag |
| regWrEn | input | 1 | CPU write strobe for the register |
| regWrData | input | 8 | CPU write data |
| regRdData | output | 8 | Register readback |
| storeStrobe | input | 1 | Store-to-program-memory instruction executed |
| storeAddr | input | ADDR_W | Word address of the store or program-memory read |
| storeDataLo | input | 8 | Low data byte of the store |
| storeDataHi | input | 8 | High data byte of the store |
| progMemRead | input | 1 | Program-memory read instruction executed |
| flashDone | input | 1 | Flash array reports completion of the running operation |
| readyIrq | output | 1 | Ready interrupt request |
| sectionBusy | output | 1 | RWW section blocked for reading |
| eraseStart | output | 1 | Page erase start pulse |
| writeStart | output | 1 | Page write start pulse |
| lockStart | output | 1 | Lock-bit set start pulse |
| loadStart | output | 1 | Buffer load pulse |
| loadAbort | output | 1 | Buffer discard pulse |
| lockBits | output | 8 | Stored lock bits |
| lockReadHit | output | 1 | Program-memory read falls in the lock/fuse read window |
| lockReadFuse | output | 1 | Read window selects fuse bits (1) or lock bits (0) |

## Verification
The hardest case is an abort that coincides with a held buffer while a flash operation is still running. The re-enable write must then be ignored, with no abort and no change to the command bits. Later, once the operation completes, the same write must abort the load. To reach this, the stimulus first leaves a buffer load pending and then starts an erase. It writes the re-enable pattern during the erase and again after flashDone, checking the start/abort pulses and the readback at each step. The window edges are reached by placing the strobe exactly in the fourth cycle after the write, and by leaving it out for four cycles.

// File: rtl/flash_prog_pkg.sv
package flash_prog_pkg;

  // command field positions inside bits 4:0 (decoded by the sequencer)
  localparam int CMD_EN = 0;
  localparam int CMD_ER = 1;
  localparam int CMD_WR = 2;
  localparam int CMD_LK = 3;
  localparam int CMD_RE = 4;
  localparam int CMD_W  = 5;

  typedef enum logic [2:0] {
    OP_IDLE,
    OP_REEN,
    OP_LOCK,
    OP_WRITE,
    OP_ERASE,
    OP_LOAD
  } opKind_t;

  // strobes from control to the register datapath
  typedef struct packed {
    logic wrIe;
    logic wrCmd;
    logic clearCmd;
    logic setBusy;
    logic clearBusy;
    logic captureLock;
  } regStrobes_t;

endpackage

// File: rtl/flash_prog_seq.sv
module flash_prog_seq
  import flash_prog_pkg::*;
#(
  parameter int ADDR_W      = 13,
  parameter int WIN_LEN     = 4,
  parameter int LOCK_RD_LEN = 3,
  parameter int RWW_WORDS   = 7168
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              wrEnBit,
  input  logic              wrReenBit,
  input  logic              wrLockBit,
  input  logic              storeStrobe,
  input  logic [ADDR_W-1:0] storeAddr,
  input  logic              progMemRead,
  input  logic              flashDone,
  input  logic [CMD_W-1:0]  cmdBits,
  output regStrobes_t       strb,
  output logic              eraseStart,
  output logic              writeStart,
  output logic              lockStart,
  output logic              loadStart,
  output logic              loadAbort,
  output logic              lockReadHit,
  output logic              lockReadFuse
);

  localparam int CNT_W = $clog2(WIN_LEN + 1);
  localparam logic [CNT_W-1:0]  ARM_LOAD = CNT_W'(WIN_LEN);
  localparam logic [CNT_W-1:0]  ARM_LAST = CNT_W'(1);
  localparam logic [ADDR_W-1:0] RWW_LIM  = ADDR_W'(RWW_WORDS);

  logic [CNT_W-1:0] armCnt;
  logic opActive;
  logic loadPending;
  logic armed, wrOk, accept, expire, opDone, inRww;
  opKind_t kind;

  always_comb begin
    armed  = (armCnt != '0);
    wrOk   = regWrEn && !opActive;
    accept = armed && storeStrobe && !regWrEn;
    expire = armed && !storeStrobe && !regWrEn && (armCnt == ARM_LAST);
    opDone = opActive && flashDone;
    inRww  = (storeAddr < RWW_LIM);
    kind   = OP_IDLE;
    if (accept) begin
      if (cmdBits[CMD_RE])      kind = OP_REEN;
      else if (cmdBits[CMD_LK]) kind = OP_LOCK;
      else if (cmdBits[CMD_WR]) kind = OP_WRITE;
      else if (cmdBits[CMD_ER]) kind = OP_ERASE;
      else                      kind = OP_LOAD;
    end
  end

  always_comb begin
    strb.wrIe        = regWrEn;
    strb.wrCmd       = wrOk;
    strb.clearCmd    = !wrOk && (expire || opDone ||
                                 (kind == OP_REEN) || (kind == OP_LOAD));
    strb.setBusy     = ((kind == OP_ERASE) || (kind == OP_WRITE)) && inRww;
    strb.clearBusy   = (kind == OP_REEN) || (kind == OP_LOAD);
    strb.captureLock = (kind == OP_LOCK);
  end

  assign eraseStart = (kind == OP_ERASE);
  assign writeStart = (kind == OP_WRITE);
  assign lockStart  = (kind == OP_LOCK);
  assign loadStart  = (kind == OP_LOAD);
  assign loadAbort  = wrOk && wrReenBit && loadPending;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      armCnt      <= '0;
      opActive    <= 1'b0;
      loadPending <= 1'b0;
    end else begin
      if (wrOk)                 armCnt <= wrEnBit ? ARM_LOAD : '0;
      else if (accept || expire) armCnt <= '0;
      else if (armed)           armCnt <= armCnt - 1'b1;

      if (eraseStart || writeStart || lockStart) opActive <= 1'b1;
      else if (opDone)                           opActive <= 1'b0;

      if (loadStart)                      loadPending <= 1'b1;
      else if (writeStart || loadAbort)   loadPending <= 1'b0;
    end
  end

  generate
    if (LOCK_RD_LEN > 0) begin : g_lockWin
      localparam int LW = $clog2(LOCK_RD_LEN + 1);
      logic [LW-1:0] lockRdCnt;
      always_ff @(posedge clk) begin
        if (!rstN)               lockRdCnt <= '0;
        else if (wrOk)           lockRdCnt <= (wrLockBit && wrEnBit) ? LW'(LOCK_RD_LEN) : '0;
        else if (lockRdCnt != '0) lockRdCnt <= lockRdCnt - 1'b1;
      end
      assign lockReadHit = progMemRead && (lockRdCnt != '0);
    end else begin : g_noLockWin
      assign lockReadHit = 1'b0;
    end
  endgenerate

  assign lockReadFuse = lockReadHit && storeAddr[0];

endmodule

// File: rtl/flash_prog_regs.sv
module flash_prog_regs
  import flash_prog_pkg::*;
#(
  parameter int LOCK_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  regStrobes_t       strb,
  input  logic              wrIeVal,
  input  logic [CMD_W-1:0]  wrCmdVal,
  input  logic [LOCK_W-1:0] lockIn,
  input  logic              globalIntEn,
  output logic [CMD_W-1:0]  cmdBits,
  output logic [7:0]        regRd,
  output logic [LOCK_W-1:0] lockBits,
  output logic              readyIrq,
  output logic              sectionBusy
);

  logic intEn;
  logic rwwBusy;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      intEn    <= 1'b0;
      rwwBusy  <= 1'b0;
      cmdBits  <= '0;
      lockBits <= '0;
    end else begin
      if (strb.wrIe) intEn <= wrIeVal;

      if (strb.wrCmd)         cmdBits <= wrCmdVal[CMD_EN] ? wrCmdVal : '0;
      else if (strb.clearCmd) cmdBits <= '0;

      if (strb.setBusy)        rwwBusy <= 1'b1;
      else if (strb.clearBusy) rwwBusy <= 1'b0;

      if (strb.captureLock) lockBits <= lockIn;
    end
  end

  assign regRd       = {intEn, rwwBusy, 1'b0, cmdBits};
  assign readyIrq    = intEn && globalIntEn && !cmdBits[CMD_EN];
  assign sectionBusy = rwwBusy;

endmodule

// File: rtl/flash_prog_ctl.sv
module flash_prog_ctl
  import flash_prog_pkg::*;
#(
  parameter int ADDR_W      = 13,
  parameter int WIN_LEN     = 4,
  parameter int LOCK_RD_LEN = 3,
  parameter int RWW_WORDS   = 7168
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              globalIntEn,
  input  logic              regWrEn,
  input  logic [7:0]        regWrData,
  output logic [7:0]        regRdData,
  input  logic              storeStrobe,
  input  logic [ADDR_W-1:0] storeAddr,
  input  logic [7:0]        storeDataLo,
  input  logic [7:0]        storeDataHi,
  input  logic              progMemRead,
  input  logic              flashDone,
  output logic              readyIrq,
  output logic              sectionBusy,
  output logic              eraseStart,
  output logic              writeStart,
  output logic              lockStart,
  output logic              loadStart,
  output logic              loadAbort,
  output logic [7:0]        lockBits,
  output logic              lockReadHit,
  output logic              lockReadFuse
);

  regStrobes_t      strb;
  logic [CMD_W-1:0] cmdBits;
  logic             unusedIn;

  // high store byte and bits 6:5 of a CPU write carry no meaning here
  assign unusedIn = ^{regWrData[6:5], storeDataHi};

  flash_prog_seq #(
    .ADDR_W(ADDR_W), .WIN_LEN(WIN_LEN),
    .LOCK_RD_LEN(LOCK_RD_LEN), .RWW_WORDS(RWW_WORDS)
  ) u_seq (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn),
    .wrEnBit(regWrData[CMD_EN]), .wrReenBit(regWrData[CMD_RE]),
    .wrLockBit(regWrData[CMD_LK]),
    .storeStrobe(storeStrobe), .storeAddr(storeAddr),
    .progMemRead(progMemRead), .flashDone(flashDone),
    .cmdBits(cmdBits), .strb(strb),
    .eraseStart(eraseStart), .writeStart(writeStart),
    .lockStart(lockStart), .loadStart(loadStart), .loadAbort(loadAbort),
    .lockReadHit(lockReadHit), .lockReadFuse(lockReadFuse)
  );

  flash_prog_regs #(.LOCK_W(8)) u_regs (
    .clk(clk), .rstN(rstN), .strb(strb),
    .wrIeVal(regWrData[7]), .wrCmdVal(regWrData[CMD_W-1:0]),
    .lockIn(storeDataLo), .globalIntEn(globalIntEn),
    .cmdBits(cmdBits), .regRd(regRdData), .lockBits(lockBits),
    .readyIrq(readyIrq), .sectionBusy(sectionBusy)
  );

endmodule

// File: rtl/flash_prog_ctl_chk.sv
module flash_prog_ctl_chk #(
  parameter int ADDR_W    = 13,
  parameter int WIN_LEN   = 4,
  parameter int RWW_WORDS = 7168
) (
  input logic              clk,
  input logic              rstN,
  input logic              globalIntEn,
  input logic              regWrEn,
  input logic [7:0]        regWrData,
  input logic [7:0]        regRdData,
  input logic              storeStrobe,
  input logic [ADDR_W-1:0] storeAddr,
  input logic              progMemRead,
  input logic              flashDone,
  input logic              readyIrq,
  input logic              eraseStart,
  input logic              writeStart,
  input logic              lockStart,
  input logic              loadStart,
  input logic              loadAbort,
  input logic              lockReadHit
);

  localparam int AW = $clog2(WIN_LEN + 1);
  localparam logic [AW-1:0]     AGE_MAX = AW'(WIN_LEN);
  localparam logic [ADDR_W-1:0] RWW_LIM = ADDR_W'(RWW_WORDS);

  logic [AW-1:0] armAge;
  logic          opFlag;
  logic          unusedChk;

  assign unusedChk = ^{regWrData[7:5], regWrData[3:1]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      armAge <= '0;
      opFlag <= 1'b0;
    end else begin
      if (regWrEn && !opFlag)                  armAge <= regWrData[0] ? AW'(1) : '0;
      else if (armAge != '0) begin
        if (storeStrobe || armAge == AGE_MAX)  armAge <= '0;
        else                                   armAge <= armAge + 1'b1;
      end
      if (eraseStart || writeStart || lockStart) opFlag <= 1'b1;
      else if (flashDone)                        opFlag <= 1'b0;
    end
  end

  a_r3_irq_only_idle: assert property (@(posedge clk) disable iff (!rstN)
    readyIrq |-> (regRdData[7] && !regRdData[0] && globalIntEn));

  a_r3_irq_when_idle: assert property (@(posedge clk) disable iff (!rstN)
    (regRdData[7] && !regRdData[0] && globalIntEn) |-> readyIrq);

  a_r4_window_expires: assert property (@(posedge clk) disable iff (!rstN)
    (armAge == AGE_MAX && !storeStrobe && !regWrEn) |=> !regRdData[0]);

  a_r5_single_start: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({eraseStart, writeStart, lockStart, loadStart}));

  a_r6_busy_on_rww: assert property (@(posedge clk) disable iff (!rstN)
    ((eraseStart || writeStart) && storeAddr < RWW_LIM) |=> regRdData[6]);

  a_r6_done_clears_en: assert property (@(posedge clk) disable iff (!rstN)
    (opFlag && flashDone) |=> !regRdData[0]);

  a_r7_load_clears: assert property (@(posedge clk) disable iff (!rstN)
    loadStart |=> (!regRdData[6] && !regRdData[0]));

  a_r8_cmd_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (opFlag && regWrEn && !flashDone) |=> (regRdData[4:0] == $past(regRdData[4:0])));

  a_r9_abort_by_write: assert property (@(posedge clk) disable iff (!rstN)
    loadAbort |-> (regWrEn && regWrData[4]));

  a_r11_hit_on_read: assert property (@(posedge clk) disable iff (!rstN)
    lockReadHit |-> progMemRead);

endmodule

bind flash_prog_ctl flash_prog_ctl_chk #(
  .ADDR_W(ADDR_W), .WIN_LEN(WIN_LEN), .RWW_WORDS(RWW_WORDS)
) u_chk (
  .clk(clk), .rstN(rstN), .globalIntEn(globalIntEn),
  .regWrEn(regWrEn), .regWrData(regWrData), .regRdData(regRdData),
  .storeStrobe(storeStrobe), .storeAddr(storeAddr),
  .progMemRead(progMemRead), .flashDone(flashDone), .readyIrq(readyIrq),
  .eraseStart(eraseStart), .writeStart(writeStart), .lockStart(lockStart),
  .loadStart(loadStart), .loadAbort(loadAbort), .lockReadHit(lockReadHit)
);

// File: tb/flash_prog_ctl_bench.sv
module flash_prog_ctl_bench;

  localparam int ADDR_W = 13;
  localparam int SEL_REG = 0, SEL_IRQ = 1, SEL_PULSE = 2, SEL_LOCK = 3, SEL_LRD = 4, SEL_BUSY = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic globalIntEn = 1'b0;
  logic regWrEn = 1'b0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic storeStrobe = 1'b0;
  logic [ADDR_W-1:0] storeAddr = '0;
  logic [7:0] storeDataLo = '0;
  logic [7:0] storeDataHi = '0;
  logic progMemRead = 1'b0;
  logic flashDone = 1'b0;
  logic readyIrq, sectionBusy, eraseStart, writeStart, lockStart, loadStart, loadAbort;
  logic [7:0] lockBits;
  logic lockReadHit, lockReadFuse;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    string      req;
    int         sel;
    logic [7:0] val;
    int         at;
  } item_t;
  item_t q[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  flash_prog_ctl u_flash_prog_ctl (
    .clk(clk), .rstN(rstN), .globalIntEn(globalIntEn),
    .regWrEn(regWrEn), .regWrData(regWrData), .regRdData(regRdData),
    .storeStrobe(storeStrobe), .storeAddr(storeAddr),
    .storeDataLo(storeDataLo), .storeDataHi(storeDataHi),
    .progMemRead(progMemRead), .flashDone(flashDone),
    .readyIrq(readyIrq), .sectionBusy(sectionBusy),
    .eraseStart(eraseStart), .writeStart(writeStart), .lockStart(lockStart),
    .loadStart(loadStart), .loadAbort(loadAbort), .lockBits(lockBits),
    .lockReadHit(lockReadHit), .lockReadFuse(lockReadFuse)
  );

  function automatic logic [7:0] observe(int sel);
    case (sel)
      SEL_REG:   return regRdData;
      SEL_IRQ:   return {7'd0, readyIrq};
      SEL_PULSE: return {3'd0, loadAbort, eraseStart, writeStart, lockStart, loadStart};
      SEL_LOCK:  return lockBits;
      SEL_LRD:   return {6'd0, lockReadHit, lockReadFuse};
      default:   return {7'd0, sectionBusy};
    endcase
  endfunction

  // monitor: compares queued expectations in their cycle, away from the edges
  initial begin
    forever begin
      @(negedge clk);
      #1;
      for (int i = q.size() - 1; i >= 0; i--) begin
        if (q[i].at == cyc) begin
          logic [7:0] got;
          got = observe(q[i].sel);
          checks++;
          if (got !== q[i].val) begin
            errors++;
            $display("FAIL %s sel=%0d cycle=%0d actual=%02h expected=%02h",
                     q[i].req, q[i].sel, cyc, got, q[i].val);
          end
          q.delete(i);
        end
      end
    end
  end

  task automatic expect_at(string req, int sel, logic [7:0] val, int ofs);
    item_t it;
    it.req = req; it.sel = sel; it.val = val; it.at = cyc + ofs;
    q.push_back(it);
  endtask

  task automatic nx();
    @(negedge clk);
    regWrEn = 1'b0; storeStrobe = 1'b0; progMemRead = 1'b0; flashDone = 1'b0;
  endtask

  task automatic cpuWrite(logic [7:0] d);
    nx(); regWrEn = 1'b1; regWrData = d;
  endtask

  task automatic store(logic [ADDR_W-1:0] a, logic [7:0] lo, logic [7:0] hi);
    nx(); storeStrobe = 1'b1; storeAddr = a; storeDataLo = lo; storeDataHi = hi;
  endtask

  task automatic finishOp(logic [7:0] after);
    nx(); flashDone = 1'b1;
    expect_at("R6", SEL_REG, after, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    nx();
    expect_at("R1", SEL_REG, 8'h00, 0);
    expect_at("R1", SEL_IRQ, 8'h00, 0);
    expect_at("R1", SEL_LOCK, 8'h00, 0);
    expect_at("R1", SEL_PULSE, 8'h00, 0);
    globalIntEn = 1'b1;

    // R2 / R3: reserved and busy bits ignore writes, interrupt follows flags
    cpuWrite(8'hE0);
    expect_at("R2", SEL_REG, 8'h80, 1);
    expect_at("R3", SEL_IRQ, 8'h01, 1);
    nx();
    nx(); globalIntEn = 1'b0;
    expect_at("R3", SEL_IRQ, 8'h00, 0);
    nx(); globalIntEn = 1'b1;
    expect_at("R3", SEL_IRQ, 8'h01, 0);

    // R4: window expires with no strobe
    cpuWrite(8'h81);
    expect_at("R3", SEL_IRQ, 8'h00, 1);
    expect_at("R4", SEL_REG, 8'h81, 4);
    expect_at("R4", SEL_PULSE, 8'h00, 4);
    expect_at("R4", SEL_REG, 8'h80, 5);
    expect_at("R4", SEL_IRQ, 8'h01, 5);
    repeat (5) nx();

    // R4 / R5: strobe in the last window cycle -> buffer load
    cpuWrite(8'h81);
    repeat (3) nx();
    store(13'h0020, 8'h11, 8'h22);
    expect_at("R4", SEL_PULSE, 8'h01, 0);
    expect_at("R5", SEL_REG, 8'h80, 1);

    // R6 / R8: erase in RWW section, writes ignored while running
    cpuWrite(8'h83);
    store(13'h0010, 8'h00, 8'h00);
    expect_at("R5", SEL_PULSE, 8'h08, 0);
    expect_at("R6", SEL_REG, 8'hC3, 1);
    expect_at("R6", SEL_BUSY, 8'h01, 1);
    expect_at("R6", SEL_IRQ, 8'h00, 1);
    cpuWrite(8'h91);
    expect_at("R8", SEL_PULSE, 8'h00, 0);
    expect_at("R8", SEL_REG, 8'hC3, 1);
    store(13'h0010, 8'h00, 8'h00);
    expect_at("R8", SEL_PULSE, 8'h00, 0);
    expect_at("R8", SEL_REG, 8'hC3, 1);
    finishOp(8'hC0);
    expect_at("R3", SEL_IRQ, 8'h01, 1);

    // R9 / R7: re-enable write aborts pending load, strobe clears busy
    cpuWrite(8'h91);
    expect_at("R9", SEL_PULSE, 8'h10, 0);
    store(13'h0000, 8'h00, 8'h00);
    expect_at("R7", SEL_PULSE, 8'h00, 0);
    expect_at("R7", SEL_REG, 8'h80, 1);
    expect_at("R7", SEL_BUSY, 8'h00, 1);
    cpuWrite(8'h90);
    expect_at("R9", SEL_PULSE, 8'h00, 0);
    expect_at("R12", SEL_REG, 8'h80, 1);

    // R6: erase outside RWW section leaves busy clear
    cpuWrite(8'h83);
    store(13'd7168, 8'h00, 8'h00);
    expect_at("R6", SEL_PULSE, 8'h08, 0);
    expect_at("R6", SEL_REG, 8'h83, 1);
    finishOp(8'h80);

    // R9 / R7: page write consumes the buffer; load clears busy
    cpuWrite(8'h81);
    store(13'h0000, 8'h00, 8'h00);
    expect_at("R5", SEL_PULSE, 8'h01, 0);
    cpuWrite(8'h85);
    store(13'h0000, 8'h00, 8'h00);
    expect_at("R5", SEL_PULSE, 8'h04, 0);
    expect_at("R6", SEL_REG, 8'hC5, 1);
    finishOp(8'hC0);
    cpuWrite(8'h90);
    expect_at("R9", SEL_PULSE, 8'h00, 0);
    expect_at("R2", SEL_REG, 8'hC0, 1);
    cpuWrite(8'h81);
    store(13'h0000, 8'h00, 8'h00);
    expect_at("R7", SEL_PULSE, 8'h01, 0);
    expect_at("R7", SEL_REG, 8'h80, 1);

    // R10 / R5: lock set wins over write and erase
    cpuWrite(8'h8F);
    store(13'h0005, 8'h3C, 8'hFF);
    expect_at("R10", SEL_PULSE, 8'h02, 0);
    expect_at("R10", SEL_LOCK, 8'h3C, 1);
    expect_at("R10", SEL_REG, 8'h8F, 1);
    finishOp(8'h80);
    cpuWrite(8'h87);
    store(13'd7168, 8'h00, 8'h00);
    expect_at("R5", SEL_PULSE, 8'h04, 0);
    finishOp(8'h80);
    cpuWrite(8'h9F);
    store(13'h0000, 8'h55, 8'h00);
    expect_at("R5", SEL_PULSE, 8'h00, 0);
    expect_at("R5", SEL_REG, 8'h80, 1);
    expect_at("R10", SEL_LOCK, 8'h3C, 1);

    // R11: lock/fuse read window
    cpuWrite(8'h89);
    nx(); progMemRead = 1'b1; storeAddr = 13'h0001;
    expect_at("R11", SEL_LRD, 8'h03, 0);
    nx(); progMemRead = 1'b1; storeAddr = 13'h0000;
    expect_at("R11", SEL_LRD, 8'h02, 0);
    nx(); progMemRead = 1'b1; storeAddr = 13'h0001;
    expect_at("R11", SEL_LRD, 8'h03, 0);
    nx(); progMemRead = 1'b1;
    expect_at("R11", SEL_LRD, 8'h00, 0);
    expect_at("R4", SEL_REG, 8'h89, 0);
    nx();
    expect_at("R4", SEL_REG, 8'h80, 0);
    expect_at("R11", SEL_LOCK, 8'h3C, 0);

    // R12: write without enable cancels the window
    cpuWrite(8'h85);
    cpuWrite(8'h84);
    expect_at("R12", SEL_REG, 8'h80, 1);
    store(13'h0000, 8'h00, 8'h00);
    expect_at("R12", SEL_PULSE, 8'h00, 0);
    expect_at("R12", SEL_REG, 8'h80, 1);

    repeat (3) nx();
    if (q.size() != 0) begin
      errors += q.size();
      checks += q.size();
      $display("FAIL R1 unchecked=%0d actual=pending expected=none", q.size());
    end
    done = 1'b1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule